// File: doc/BRIEF.md
# Flagged Arithmetic Logic Unit

This block is the arithmetic and logic core of a small teaching processor. It takes two 16-bit two's-complement operands and a 4-bit operation select. In the same cycle it returns a 19-bit result and a 5-bit status word. Inside, each operand is widened to 19 bits by copying its bit 15 into three guard bits. Add, subtract and increment therefore produce their exact signed value even when that value no longer fits in 16 bits.

A flag register stands next to the combinational datapath. It captures the status word on a rising clock edge while `flag_en` is high, so that later conditional jumps can test it. Jump-on-carry uses the carry bit, jump-on-sign the sign bit, jump-on-parity the parity bit, jump-on-zero the zero bit and jump-on-overflow the overflow bit. Reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `flag_alu`

## Requirements
- R1: `op_sel` encodes 0 ADD, 1 SUB, 2 INC, 3 MUL, 4 DIV, 5 AND, 6 OR, 7 NOT (of A), 8 XOR, 9 SHL, 10 SHR, 11 ROL, 12 ROR. Codes 13 to 15 give a zero result, with carry and overflow clear and the other flags derived from that zero result.
- R2: For ADD (A+B), SUB (A-B) and INC (A+1), `result` is the exact 19-bit two's-complement value computed on the sign-extended operands. Overflow is set when that value lies outside -32768..32767.
- R3: Carry is the unsigned carry out of bit 15 for ADD. For SUB it is the borrow, set when A < B taken as unsigned values. For INC it is set when A was 0xFFFF.
- R4: MUL returns the low 16 bits of the signed product. Overflow is set when the full product lies outside -32768..32767. Carry is clear.
- R5: DIV returns the signed quotient, truncated toward zero. A zero divisor gives a quotient of 0 with overflow set. -32768 / -1 gives 0x8000 with overflow set. Carry is clear.
- R6: AND, OR, XOR and NOT are bitwise operations. They clear carry and overflow.
- R7: SHL and SHR shift by one position and fill the vacated bit with 0. The bit shifted out goes to carry. Overflow is clear.
- R8: ROL and ROR rotate the 16-bit value by one position. Carry and overflow are clear.
- R9: For every code other than ADD, SUB and INC, `result[18:16]` are copies of `result[15]`.
- R10: Bit layout of the status word: bit 4 parity (set when `result[15:0]` holds an even number of ones), bit 3 sign (`result[15]`), bit 2 overflow, bit 1 carry, bit 0 zero (`result[15:0]` == 0). `flags_now` is valid in the same cycle as the inputs.
- R11: `flags_q` loads `flags_now` on a rising edge of `clk` while `flag_en` is high. Asserting `rst_n` low clears it to 0 at once. It stays 0 until the released reset has passed the synchroniser.
- R12: While `flag_en` is low, `flags_q` keeps its value whatever the operands and the operation are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| op_a | input | 16 | Operand A, two's complement |
| op_b | input | 16 | Operand B, two's complement |
| op_sel | input | 4 | Operation code |
| flag_en | input | 1 | Load enable for the flag register |
| result | output | 19 | Sign-extended result |
| flags_now | output | 5 | Status of the current operation |
| flags_q | output | 5 | Registered status word |

## Verification
The datapath holds no state, so a fault there shows up in `result` or `flags_now` in the same cycle as the operands that exercise it. The only state is the flag register. If it loads wrongly or fails to hold, `flags_q` differs from the model at the next falling edge after the rising edge concerned. The reference model therefore compares all three outputs on every cycle. Directed vectors hit the carry, borrow, overflow and divide-by-zero edges, and random vectors with a random enable cover the rest.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_MUL = 4'd3,
    OP_DIV = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_NOT = 4'd7,
    OP_XOR = 4'd8,
    OP_SHL = 4'd9,
    OP_SHR = 4'd10,
    OP_ROL = 4'd11,
    OP_ROR = 4'd12
  } alu_op_e;

  // MSB first: parity, sign, overflow, carry, zero
  typedef struct packed {
    logic parity;
    logic sign;
    logic ovf;
    logic carry;
    logic zero;
  } alu_flags_t;

  localparam int FL_ZERO  = 0;
  localparam int FL_CARRY = 1;
  localparam int FL_OVF   = 2;
  localparam int FL_SIGN  = 3;
  localparam int FL_PAR   = 4;

endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import flag_alu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 3
) (
  input  logic [DATA_W-1:0]         a,
  input  logic [DATA_W-1:0]         b,
  input  alu_op_e                   op,
  output logic [DATA_W+GUARD_W-1:0] res_ext,
  output logic                      carry,
  output logic                      ovf
);
  localparam int EXT_W  = DATA_W + GUARD_W;
  localparam int PROD_W = 2 * DATA_W;
  localparam int MSB    = DATA_W - 1;

  logic [EXT_W-1:0] a_x, b_x, sum_x, diff_x, inc_x;
  logic             add_c, sub_c, inc_c;
  logic             add_v, sub_v, inc_v;

  // guard bits replicate the sign of each operand
  assign a_x = {{GUARD_W{a[MSB]}}, a};
  assign b_x = {{GUARD_W{b[MSB]}}, b};

  assign sum_x  = a_x + b_x;
  assign diff_x = a_x - b_x;
  assign inc_x  = a_x + {{(EXT_W-1){1'b0}}, 1'b1};

  assign add_c = (a[MSB] & b[MSB]) | ((a[MSB] ^ b[MSB]) & ~sum_x[MSB]);
  assign sub_c = (a < b);
  assign inc_c = &a;

  // exact value fits in DATA_W+1 bits: mismatch of the top two means overflow
  assign add_v = sum_x[DATA_W]  ^ sum_x[MSB];
  assign sub_v = diff_x[DATA_W] ^ diff_x[MSB];
  assign inc_v = inc_x[DATA_W]  ^ inc_x[MSB];

  // multiply
  logic signed [PROD_W-1:0] prod;
  logic [PROD_W-DATA_W:0]   prod_hi;
  logic                     mul_v;

  assign prod    = $signed({{DATA_W{a[MSB]}}, a}) * $signed({{DATA_W{b[MSB]}}, b});
  assign prod_hi = prod[PROD_W-1:MSB];
  assign mul_v   = ~((&prod_hi) | ~(|prod_hi));

  // divide, one extra bit so that the most negative / -1 is representable
  logic                     b_zero;
  logic signed [DATA_W:0]   dvd, dvs, quo;
  logic [MSB:0]             div_res;
  logic                     div_v;

  assign b_zero  = ~(|b);
  assign dvd     = $signed({a[MSB], a});
  assign dvs     = b_zero ? $signed({{DATA_W{1'b0}}, 1'b1}) : $signed({b[MSB], b});
  assign quo     = dvd / dvs;
  assign div_res = b_zero ? '0 : quo[MSB:0];
  assign div_v   = b_zero | (quo[DATA_W] ^ quo[MSB]);

  always_comb begin
    res_ext = '0;
    carry   = 1'b0;
    ovf     = 1'b0;
    unique case (op)
      OP_ADD: begin res_ext = sum_x;  carry = add_c; ovf = add_v; end
      OP_SUB: begin res_ext = diff_x; carry = sub_c; ovf = sub_v; end
      OP_INC: begin res_ext = inc_x;  carry = inc_c; ovf = inc_v; end
      OP_MUL: begin
        res_ext = {{GUARD_W{prod[MSB]}}, prod[MSB:0]};
        ovf     = mul_v;
      end
      OP_DIV: begin
        res_ext = {{GUARD_W{div_res[MSB]}}, div_res};
        ovf     = div_v;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] res,
  output logic              carry
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    res   = '0;
    carry = 1'b0;
    unique case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_NOT: res = ~a;
      OP_XOR: res = a ^ b;
      OP_SHL: begin res = {a[MSB-1:0], 1'b0}; carry = a[MSB]; end
      OP_SHR: begin res = {1'b0, a[MSB:1]};   carry = a[0];   end
      OP_ROL: res = {a[MSB-1:0], a[MSB]};
      OP_ROR: res = {a[0], a[MSB:1]};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res,
  input  logic              carry,
  input  logic              ovf,
  output alu_flags_t        flags
);
  logic [DATA_W:0] par_chain;

  assign par_chain[0] = 1'b1;
  for (genvar i = 0; i < DATA_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ res[i];
  end

  always_comb begin
    flags.parity = par_chain[DATA_W];
    flags.sign   = res[DATA_W-1];
    flags.ovf    = ovf;
    flags.carry  = carry;
    flags.zero   = ~(|res);
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import flag_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  alu_flags_t d,
  output alu_flags_t q
);
  alu_flags_t q_next;

  always_comb begin
    q_next = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         op_a,
  input  logic [DATA_W-1:0]         op_b,
  input  logic [3:0]                op_sel,
  input  logic                      flag_en,
  output logic [DATA_W+GUARD_W-1:0] result,
  output logic [4:0]                flags_now,
  output logic [4:0]                flags_q
);
  localparam int EXT_W = DATA_W + GUARD_W;
  localparam int MSB   = DATA_W - 1;

  alu_op_e          op;
  logic [EXT_W-1:0] ar_res;
  logic             ar_c, ar_v;
  logic [MSB:0]     lg_res;
  logic             lg_c;
  logic             sel_c, sel_v;
  logic             srst_n;
  alu_flags_t       fl_now, fl_q;

  assign op = alu_op_e'(op_sel);

  alu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(srst_n)
  );

  alu_arith #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_arith (
    .a(op_a), .b(op_b), .op(op), .res_ext(ar_res), .carry(ar_c), .ovf(ar_v)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a(op_a), .b(op_b), .op(op), .res(lg_res), .carry(lg_c)
  );

  always_comb begin
    result = '0;
    sel_c  = 1'b0;
    sel_v  = 1'b0;
    if (op inside {OP_ADD, OP_SUB, OP_INC, OP_MUL, OP_DIV}) begin
      result = ar_res;
      sel_c  = ar_c;
      sel_v  = ar_v;
    end else if (op inside {OP_AND, OP_OR, OP_NOT, OP_XOR,
                            OP_SHL, OP_SHR, OP_ROL, OP_ROR}) begin
      result = {{GUARD_W{lg_res[MSB]}}, lg_res};
      sel_c  = lg_c;
    end
  end

  alu_flag_gen #(.DATA_W(DATA_W)) u_fgen (
    .res(result[MSB:0]), .carry(sel_c), .ovf(sel_v), .flags(fl_now)
  );

  alu_flag_reg u_freg (
    .clk(clk), .rst_n(srst_n), .en(flag_en), .d(fl_now), .q(fl_q)
  );

  assign flags_now = fl_now;
  assign flags_q   = fl_q;

  // ---------------- assertions ----------------
  logic past_ok;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_div0_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (op_sel == 4'd4 && op_b == '0) |-> (flags_now[FL_OVF] && result == '0));

  assert_guard_copy_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (op_sel > 4'd2) |-> (result[EXT_W-1:DATA_W] == {GUARD_W{result[MSB]}}));

  assert_bitwise_clear_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (op_sel >= 4'd5 && op_sel <= 4'd8) |-> (flags_now[FL_OVF:FL_CARRY] == 2'b00));

  assert_shl_carry_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (op_sel == 4'd9) |-> (flags_now[FL_CARRY] == op_a[MSB]));

  assert_flag_load_R11: assert property (@(posedge clk) disable iff (!srst_n)
    (past_ok && $past(flag_en)) |-> (flags_q == $past(flags_now)));

  assert_flag_hold_R12: assert property (@(posedge clk) disable iff (!srst_n)
    (past_ok && !$past(flag_en)) |-> $stable(flags_q));

endmodule

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] op_a, op_b;
  logic [3:0]  op_sel;
  logic        flag_en;
  logic [18:0] result;
  logic [4:0]  flags_now, flags_q;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_q;

  always #2 clk = ~clk;   // 250 MHz

  flag_alu dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flag_en(flag_en), .result(result), .flags_now(flags_now), .flags_q(flags_q)
  );

  // behavioural reference, built from the requirements
  function automatic void model(input logic [15:0] a, input logic [15:0] b,
                                input logic [3:0] op,
                                output logic [18:0] r, output logic [4:0] f);
    integer ai, bi, ua, ub, s;
    logic [31:0] sv;
    logic [15:0] r16;
    logic c, v;
    ai = $signed(a); bi = $signed(b);
    ua = {16'd0, a}; ub = {16'd0, b};
    c = 1'b0; v = 1'b0; r16 = '0; s = 0;
    case (op)
      4'd0: begin s = ai + bi; c = (ua + ub) > 65535; end      // R2 R3
      4'd1: begin s = ai - bi; c = ua < ub; end
      4'd2: begin s = ai + 1;  c = (a == 16'hFFFF); end
      4'd3: begin s = ai * bi; end                             // R4
      4'd4: begin                                              // R5
        if (bi == 0) begin s = 0; v = 1'b1; end
        else s = ai / bi;
      end
      4'd5: r16 = a & b;                                       // R6
      4'd6: r16 = a | b;
      4'd7: r16 = ~a;
      4'd8: r16 = a ^ b;
      4'd9:  begin r16 = {a[14:0], 1'b0}; c = a[15]; end       // R7
      4'd10: begin r16 = {1'b0, a[15:1]}; c = a[0];  end
      4'd11: r16 = {a[14:0], a[15]};                           // R8
      4'd12: r16 = {a[0], a[15:1]};
      default: r16 = '0;                                       // R1
    endcase
    if (op <= 4'd4) begin
      sv  = s;
      r16 = sv[15:0];
      if (s > 32767 || s < -32768) v = 1'b1;
    end
    if (op <= 4'd2) r = sv[18:0];
    else            r = {{3{r16[15]}}, r16};                  // R9
    f = {~^r16, r16[15], v, c, (r16 == 16'd0)};               // R10
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2: return "R2/R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5, 4'd6, 4'd7, 4'd8: return "R6";
      4'd9, 4'd10: return "R7";
      4'd11, 4'd12: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
               req, op_sel, op_a, op_b, act, exp);
    end
  endtask

  // one vector: check the register from the last edge, then drive and check the datapath
  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] op, input logic en);
    logic [18:0] er;
    logic [4:0]  ef;
    @(negedge clk);
    chk("R11/R12 flags_q", {27'd0, flags_q}, {27'd0, exp_q});
    op_a = a; op_b = b; op_sel = op; flag_en = en;
    #1;
    model(a, b, op, er, ef);
    chk({tag_of(op), " R9 result"}, {13'd0, result}, {13'd0, er});
    chk({tag_of(op), " R10 flags"}, {27'd0, flags_now}, {27'd0, ef});
    if (en) exp_q = ef;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_a = 16'h7FFF; op_b = 16'h0001; op_sel = 4'd0; flag_en = 1'b1;
    exp_q = '0;
    #9;
    // R11: register held at zero while reset is active even with enable high
    chk("R11 reset", {27'd0, flags_q}, 32'd0);
    @(negedge clk);
    chk("R11 reset", {27'd0, flags_q}, 32'd0);
    flag_en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2/R3 add, sub, inc corners
    apply(16'h7FFF, 16'h0001, 4'd0, 1'b1);
    apply(16'hFFFF, 16'h0001, 4'd0, 1'b1);
    apply(16'h8000, 16'h8000, 4'd0, 1'b1);
    apply(16'h0000, 16'h0001, 4'd1, 1'b1);
    apply(16'h8000, 16'h0001, 4'd1, 1'b1);
    apply(16'h7FFF, 16'h0000, 4'd2, 1'b1);
    apply(16'hFFFF, 16'h0000, 4'd2, 1'b1);
    // R4
    apply(16'h0100, 16'h0100, 4'd3, 1'b1);
    apply(16'hFFFD, 16'h0005, 4'd3, 1'b1);
    // R5
    apply(16'h0007, 16'h0000, 4'd4, 1'b1);
    apply(16'h8000, 16'hFFFF, 4'd4, 1'b1);
    apply(16'hFFF9, 16'h0002, 4'd4, 1'b1);
    // R6
    apply(16'hF0F0, 16'h0FF0, 4'd5, 1'b1);
    apply(16'hF0F0, 16'h0F0F, 4'd6, 1'b1);
    apply(16'hFFFF, 16'h1234, 4'd7, 1'b1);
    apply(16'hAAAA, 16'hAAAA, 4'd8, 1'b1);
    // R7 R8
    apply(16'h8001, 16'h0000, 4'd9, 1'b1);
    apply(16'h0001, 16'h0000, 4'd10, 1'b1);
    apply(16'h8000, 16'h0000, 4'd11, 1'b1);
    apply(16'h0001, 16'h0000, 4'd12, 1'b1);
    // R1 reserved codes
    apply(16'h1234, 16'h5678, 4'd13, 1'b1);
    apply(16'hFFFF, 16'hFFFF, 4'd15, 1'b1);
    // R12 hold: flag-changing operations with enable low
    apply(16'h7FFF, 16'h0001, 4'd0, 1'b0);
    apply(16'h0001, 16'h0000, 4'd10, 1'b0);
    apply(16'h0000, 16'h0000, 4'd4, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (($urandom % 8) == 0) rb = 16'($urandom % 3) - 16'd1;
      apply(ra, rb, 4'($urandom % 16), 1'($urandom));
    end

    @(negedge clk);
    chk("R11/R12 flags_q", {27'd0, flags_q}, {27'd0, exp_q});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule